// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Serialization

This block is a multi-bank on-chip scratchpad that serves one vector request at a time from a group of lanes. Each lane supplies a word address, a read enable, a write enable and write data. Each bank is one word wide, so consecutive words go to consecutive banks. When several lanes need the same bank at different rows, the block splits the request into passes and runs them back to back. Lanes that name exactly the same word share one pass: a read is broadcast to all of them, and if several of them write, the highest-numbered lane's data is stored.

A requester presents a request while `req_ready` is high. The block then lowers `req_ready` until the request is finished. At the end it raises `done` for one cycle, with the read data on `lane_rdata` and the number of passes used on `pass_count`. A narrow mode, sampled with the request, groups conflicts on one fewer address bit (16 banks in the default configuration). In this mode no same-word merging takes place, so each lane in a group gets its own pass.

The controller has three states. ST_IDLE accepts a request. ST_PASS serves one pass per cycle. ST_DONE raises the completion pulse. The transitions are:
- *accept-work* (ST_IDLE→ST_PASS), when at least one lane is enabled.
- *accept-empty* (ST_IDLE→ST_DONE), when no lane is enabled.
- *more-pending* (ST_PASS→ST_PASS).
- *last-pass* (ST_PASS→ST_DONE).
- *retire* (ST_DONE→ST_IDLE).

Top module: `banked_scratchpad`

## Requirements
- R1: In wide mode (`narrow_mode`=0) the bank of a word is the low 5 bits of its word index, so word 32 is in bank 0. A unit-stride request (lane i reads word base+i) finishes in 1 pass.
- R2: In narrow mode (`narrow_mode`=1, sampled at accept) lanes are grouped by the low 4 bits of the word index. The pass count is the largest number of enabled lanes that share one group, even when they name the same word.
- R3: In wide mode the pass count is the largest number of distinct word addresses among enabled lanes that share one bank. Stride 2 across 32 lanes gives 2 passes, stride 32 gives 32 passes and stride 33 gives 1 pass.
- R4: In wide mode, lanes that read the same word are served in one pass and all receive that word.
- R5: At `done`, every reading lane's `lane_rdata` slice (lane l at bits [32l+31:32l]) holds the content the word had when its pass started.
- R6: When several lanes write the same word in one pass, the word afterwards holds the data of the highest-numbered of those lanes.
- R7: `req_ready` is low from the accepting edge until the cycle after the `done` cycle. `done` lasts one cycle. A request held on `req_valid` while busy is not taken and has no effect.
- R8: A request with no lane enabled completes with `pass_count` 0, and `done` appears in the cycle right after the accepting edge.
- R9: After reset `req_ready` is 1, `done` is 0, `pass_count` is 0 and `lane_rdata` is all zero.
- R10: `done` is high after exactly `pass_count` clock edges have followed the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| narrow_mode | input | 1 | 1 = group on 4 address bits, no same-word merge |
| lane_rd_en | input | 32 | Per-lane read enable |
| lane_wr_en | input | 32 | Per-lane write enable |
| lane_addr | input | 320 | Per-lane word address, 10 bits each, lane l at [10l+9:10l] |
| lane_wdata | input | 1024 | Per-lane write data, 32 bits each |
| done | output | 1 | One-cycle completion pulse |
| pass_count | output | 6 | Passes used by the last request |
| lane_rdata | output | 1024 | Per-lane read data, 32 bits each |

## Verification
The case that is hardest to bring about from the ports is a request that arrives while a long request is still being served. Reaching it needs a 32-pass request that stays busy for many cycles. The bench starts a stride-32 read and, at once, puts a conflicting write request on `req_valid`, holding it there until the `done` cycle. It then reads those words back to show the held request left no trace. Stride sweeps in both modes and a broadcast of one word to all lanes push the pass count to 1, to 32 and to the values in between.

// File: rtl/sp_pkg.sv
package sp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PASS = 2'd1,
        ST_DONE = 2'd2
    } sp_state_e;

endpackage

// File: rtl/sp_pass_sched.sv
module sp_pass_sched #(
    parameter int LANES     = 32,
    parameter int AW        = 10,
    parameter int BANK_BITS = 5
) (
    input  logic                         narrow,
    input  logic [LANES-1:0]             pending,
    input  logic [LANES-1:0][AW-1:0]     addr,
    output logic [LANES-1:0]             served
);

    logic [LANES-1:0][BANK_BITS-1:0] key;
    logic [LANES-1:0]                lead;

    // Conflict group of each lane: full bank index, or one bit fewer in narrow mode.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            if (narrow) begin
                key[l] = {1'b0, addr[l][BANK_BITS-2:0]};
            end else begin
                key[l] = addr[l][BANK_BITS-1:0];
            end
        end
    end

    // The lowest pending lane of each group leads that group this pass.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            lead[l] = pending[l];
            for (int j = 0; j < l; j++) begin
                if (pending[j] && key[j] == key[l]) begin
                    lead[l] = 1'b0;
                end
            end
        end
    end

    // A lane is served when it leads, or (wide mode) names its leader's word.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            served[l] = 1'b0;
            for (int m = 0; m <= l; m++) begin
                if (lead[m] && key[m] == key[l] &&
                    (m == l || (!narrow && addr[m] == addr[l]))) begin
                    served[l] = pending[l];
                end
            end
        end
    end

endmodule

// File: rtl/sp_xbar.sv
module sp_xbar #(
    parameter int LANES     = 32,
    parameter int BANK_BITS = 5,
    parameter int RW        = 5,
    parameter int DW        = 32,
    parameter int AW        = BANK_BITS + RW,
    parameter int BANKS     = 1 << BANK_BITS
) (
    input  logic [LANES-1:0]             served,
    input  logic [LANES-1:0]             wr,
    input  logic [LANES-1:0][AW-1:0]     addr,
    input  logic [LANES-1:0][DW-1:0]     wdata,
    output logic [BANKS-1:0]             bank_we,
    output logic [BANKS-1:0][RW-1:0]     bank_row,
    output logic [BANKS-1:0][DW-1:0]     bank_wd,
    input  logic [BANKS-1:0][DW-1:0]     bank_rd,
    output logic [LANES-1:0][DW-1:0]     lane_rd
);

    // Lane-to-bank routing; later lanes override earlier ones, so the highest writer wins.
    always_comb begin
        for (int b = 0; b < BANKS; b++) begin
            bank_we[b]  = 1'b0;
            bank_row[b] = '0;
            bank_wd[b]  = '0;
            for (int l = 0; l < LANES; l++) begin
                if (served[l] && addr[l][BANK_BITS-1:0] == BANK_BITS'(b)) begin
                    bank_row[b] = addr[l][AW-1:BANK_BITS];
                    if (wr[l]) begin
                        bank_we[b] = 1'b1;
                        bank_wd[b] = wdata[l];
                    end
                end
            end
        end
    end

    // Bank-to-lane return path.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            lane_rd[l] = bank_rd[addr[l][BANK_BITS-1:0]];
        end
    end

endmodule

// File: rtl/sp_bank.sv
module sp_bank #(
    parameter int ROWS = 32,
    parameter int DW   = 32,
    parameter int RW   = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [RW-1:0] row,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [ROWS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[row] <= wdata;
        end
    end

    // Read sees the word as it stood before this cycle's write.
    assign rdata = mem[row];

endmodule

// File: rtl/banked_scratchpad.sv
module banked_scratchpad
    import sp_pkg::*;
#(
    parameter int LANES     = 32,
    parameter int BANK_BITS = 5,
    parameter int ROWS      = 32,
    parameter int DW        = 32,
    localparam int BANKS    = 1 << BANK_BITS,
    localparam int RW       = $clog2(ROWS),
    localparam int AW       = BANK_BITS + RW,
    localparam int CW       = $clog2(LANES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                narrow_mode,
    input  logic [LANES-1:0]    lane_rd_en,
    input  logic [LANES-1:0]    lane_wr_en,
    input  logic [LANES*AW-1:0] lane_addr,
    input  logic [LANES*DW-1:0] lane_wdata,
    output logic                done,
    output logic [CW-1:0]       pass_count,
    output logic [LANES*DW-1:0] lane_rdata
);

    sp_state_e state_q, state_d;

    logic [LANES-1:0][AW-1:0] addr_in, addr_q;
    logic [LANES-1:0][DW-1:0] wdata_in, wdata_q;
    logic [LANES-1:0][DW-1:0] rdata_q, lane_rd;
    logic [LANES-1:0]         rd_q, wr_q, pending_q, served, served_g;
    logic                     mode_q;
    logic [CW-1:0]            cnt_q;
    logic                     accept, in_pass;

    logic [BANKS-1:0]           bank_we;
    logic [BANKS-1:0][RW-1:0]   bank_row;
    logic [BANKS-1:0][DW-1:0]   bank_wd, bank_rd;

    assign addr_in  = lane_addr;
    assign wdata_in = lane_wdata;
    assign accept   = req_valid && req_ready;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- transitions ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = (|(lane_rd_en | lane_wr_en)) ? ST_PASS : ST_DONE;
                end
            end
            ST_PASS: begin
                if ((pending_q & ~served) == '0) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        req_ready = 1'b0;
        done      = 1'b0;
        in_pass   = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_PASS: in_pass   = 1'b1;
            ST_DONE: done      = 1'b1;
            default: req_ready = 1'b0;
        endcase
    end

    assign pass_count = cnt_q;
    assign lane_rdata = rdata_q;

    // ---------------- request datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            wdata_q   <= '0;
            rd_q      <= '0;
            wr_q      <= '0;
            pending_q <= '0;
            mode_q    <= 1'b0;
            cnt_q     <= '0;
            rdata_q   <= '0;
        end else if (accept) begin
            addr_q    <= addr_in;
            wdata_q   <= wdata_in;
            rd_q      <= lane_rd_en;
            wr_q      <= lane_wr_en;
            pending_q <= lane_rd_en | lane_wr_en;
            mode_q    <= narrow_mode;
            cnt_q     <= '0;
        end else if (in_pass) begin
            pending_q <= pending_q & ~served;
            cnt_q     <= cnt_q + CW'(1);
            for (int l = 0; l < LANES; l++) begin
                if (served[l] && rd_q[l]) begin
                    rdata_q[l] <= lane_rd[l];
                end
            end
        end
    end

    // ---------------- pass selection and bank routing ----------------
    sp_pass_sched #(
        .LANES    (LANES),
        .AW       (AW),
        .BANK_BITS(BANK_BITS)
    ) u_sched (
        .narrow (mode_q),
        .pending(pending_q),
        .addr   (addr_q),
        .served (served)
    );

    assign served_g = served & {LANES{in_pass}};

    sp_xbar #(
        .LANES    (LANES),
        .BANK_BITS(BANK_BITS),
        .RW       (RW),
        .DW       (DW)
    ) u_xbar (
        .served  (served_g),
        .wr      (wr_q),
        .addr    (addr_q),
        .wdata   (wdata_q),
        .bank_we (bank_we),
        .bank_row(bank_row),
        .bank_wd (bank_wd),
        .bank_rd (bank_rd),
        .lane_rd (lane_rd)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        sp_bank #(
            .ROWS(ROWS),
            .DW  (DW)
        ) u_bank (
            .clk  (clk),
            .we   (bank_we[b]),
            .row  (bank_row[b]),
            .wdata(bank_wd[b]),
            .rdata(bank_rd[b])
        );
    end

    // ---------------- assertions ----------------
    // R3: every pass retires at least one pending lane
    a_r3_progress: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PASS) |-> (served != '0));

    // R3: the scheduler only picks lanes that are still pending
    a_r3_served_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (served & ~pending_q) == '0);

    // R7: completion is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: the block is ready again right after completion
    a_r7_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);

    // R10: pass count never exceeds the lane count
    a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pass_count <= CW'(LANES)));

    // R8: a zero-pass completion follows straight from idle
    a_r8_empty_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pass_count == '0) |-> ($past(state_q) == ST_IDLE));

endmodule

// File: tb/banked_scratchpad_tb_top.sv
`timescale 1ns/1ps
module banked_scratchpad_tb_top;

    localparam int LANES = 32;
    localparam int AW    = 10;
    localparam int DW    = 32;
    localparam int WORDS = 1024;
    localparam int CW    = 6;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                req_valid = 1'b0;
    logic                req_ready;
    logic                narrow_mode = 1'b0;
    logic [LANES-1:0]    lane_rd_en = '0;
    logic [LANES-1:0]    lane_wr_en = '0;
    logic [LANES*AW-1:0] lane_addr = '0;
    logic [LANES*DW-1:0] lane_wdata = '0;
    logic                done;
    logic [CW-1:0]       pass_count;
    logic [LANES*DW-1:0] lane_rdata;

    int nchecks = 0;
    int errors  = 0;

    logic [DW-1:0] mem_model [WORDS];
    logic [AW-1:0] a_arr [LANES];
    logic [DW-1:0] d_arr [LANES];
    logic          rd_arr [LANES];
    logic          wr_arr [LANES];

    always #2.5 clk = ~clk;

    banked_scratchpad dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .narrow_mode(narrow_mode),
        .lane_rd_en (lane_rd_en),
        .lane_wr_en (lane_wr_en),
        .lane_addr  (lane_addr),
        .lane_wdata (lane_wdata),
        .done       (done),
        .pass_count (pass_count),
        .lane_rdata (lane_rdata)
    );

    function automatic logic [DW-1:0] pat(input int a, input int salt);
        return (DW'(a) * 32'h9E3779B1) ^ (32'hC3A50000 + DW'(salt));
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        nchecks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected passes: wide = max distinct words per bank (5 bits); narrow = max lanes per 4-bit group.
    function automatic int calc_passes(input bit narrow);
        int worst = 0;
        int groups = narrow ? 16 : 32;
        for (int k = 0; k < groups; k++) begin
            int cnt = 0;
            for (int l = 0; l < LANES; l++) begin
                if ((rd_arr[l] || wr_arr[l]) && (int'(a_arr[l]) % groups) == k) begin
                    bit dup = 1'b0;
                    if (!narrow) begin
                        for (int j = 0; j < l; j++) begin
                            if ((rd_arr[j] || wr_arr[j]) && a_arr[j] == a_arr[l]) dup = 1'b1;
                        end
                    end
                    if (!dup) cnt++;
                end
            end
            if (cnt > worst) worst = cnt;
        end
        return worst;
    endfunction

    task automatic clear_lanes();
        for (int l = 0; l < LANES; l++) begin
            a_arr[l] = '0; d_arr[l] = '0; rd_arr[l] = 1'b0; wr_arr[l] = 1'b0;
        end
    endtask

    task automatic set_stride(input int base, input int stride, input bit rd, input int salt);
        for (int l = 0; l < LANES; l++) begin
            a_arr[l]  = AW'((base + l * stride) % WORDS);
            rd_arr[l] = rd;
            wr_arr[l] = !rd;
            d_arr[l]  = pat(int'(a_arr[l]), salt);
        end
    endtask

    // Issues the lane arrays as one request and checks completion; hold=1 keeps a junk
    // write request on req_valid while busy (R7).
    task automatic run_req(input bit narrow, input string req, input bit hold);
        int exp_p;
        int edges;
        bit busy_ok;
        logic [DW-1:0] snap [WORDS];
        exp_p = calc_passes(narrow);
        for (int w = 0; w < WORDS; w++) snap[w] = mem_model[w];
        for (int l = 0; l < LANES; l++) begin
            lane_addr[l*AW +: AW]  = a_arr[l];
            lane_wdata[l*DW +: DW] = d_arr[l];
            lane_rd_en[l]          = rd_arr[l];
            lane_wr_en[l]          = wr_arr[l];
        end
        narrow_mode = narrow;
        req_valid   = 1'b1;
        chk(req_ready == 1'b1, "R7", "ready before request", longint'(req_ready), 1);
        @(posedge clk); #1;
        if (hold) begin
            for (int l = 0; l < LANES; l++) begin
                lane_addr[l*AW +: AW]  = AW'(l);
                lane_wdata[l*DW +: DW] = 32'hDEAD0000 + DW'(l);
            end
            lane_rd_en = '0;
            lane_wr_en = '1;
        end else begin
            req_valid = 1'b0;
        end
        edges = 0;
        busy_ok = 1'b1;
        while (!done && edges < 80) begin
            if (req_ready) busy_ok = 1'b0;
            @(posedge clk); #1;
            edges++;
        end
        req_valid = 1'b0;
        chk(done == 1'b1, "R10", "done seen", longint'(done), 1);
        chk(edges == exp_p, "R10", "edges to done", edges, exp_p);
        chk(int'(pass_count) == exp_p, req, "pass count", longint'(pass_count), exp_p);
        chk(busy_ok && !req_ready, "R7", "ready low while busy", longint'(req_ready), 0);
        for (int l = 0; l < LANES; l++) begin
            if (rd_arr[l]) begin
                chk(lane_rdata[l*DW +: DW] == snap[a_arr[l]], "R5", $sformatf("lane %0d read", l),
                    longint'(lane_rdata[l*DW +: DW]), longint'(snap[a_arr[l]]));
            end
        end
        for (int l = 0; l < LANES; l++) begin
            if (wr_arr[l]) mem_model[a_arr[l]] = d_arr[l];
        end
        @(posedge clk); #1;
        chk(!done && req_ready, "R7", "pulse ends, ready back", longint'({done, req_ready}), 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        nchecks++;
        $display("FAIL watchdog expired: actual 1 expected 0");
        $display("  Result: errors=%0d of %0d checks", errors, nchecks);
        $finish;
    end

    initial begin : stim
        for (int w = 0; w < WORDS; w++) mem_model[w] = '0;
        clear_lanes();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R9: reset state
        chk(req_ready == 1'b1, "R9", "ready after reset", longint'(req_ready), 1);
        chk(done == 1'b0, "R9", "done after reset", longint'(done), 0);
        chk(pass_count == '0, "R9", "pass count after reset", longint'(pass_count), 0);
        chk(lane_rdata == '0, "R9", "read data after reset", longint'(lane_rdata[31:0]), 0);

        // R1: unit-stride fill of all words, one pass each
        for (int k = 0; k < WORDS / LANES; k++) begin
            set_stride(k * LANES, 1, 1'b0, 0);
            run_req(1'b0, "R1", 1'b0);
        end

        // R3/R5: wide-mode read stride sweep (covers strides 1, 2, 32, 33)
        for (int s = 0; s <= 40; s++) begin
            set_stride(5, s, 1'b1, 0);
            run_req(1'b0, "R3", 1'b0);
        end

        // R2: narrow-mode read stride sweep
        for (int s = 0; s <= 17; s++) begin
            set_stride(2, s, 1'b1, 0);
            run_req(1'b1, "R2", 1'b0);
        end

        // R4: every lane reads word 100 -> one pass wide, 32 passes narrow (R2)
        set_stride(100, 0, 1'b1, 0);
        run_req(1'b0, "R4", 1'b0);
        run_req(1'b1, "R2", 1'b0);

        // R3: partial masks, even lanes only
        for (int s = 1; s <= 32; s = s * 2) begin
            set_stride(0, s, 1'b1, 0);
            for (int l = 1; l < LANES; l += 2) rd_arr[l] = 1'b0;
            run_req(1'b0, "R3", 1'b0);
        end

        // R6: all lanes write word 200 with distinct data; highest lane wins
        clear_lanes();
        for (int l = 0; l < LANES; l++) begin
            a_arr[l] = AW'(200); wr_arr[l] = 1'b1; d_arr[l] = 32'hA0000000 + DW'(l);
        end
        run_req(1'b0, "R6", 1'b0);
        // R6: two same-bank words (300, 332), interleaved writers -> 2 passes
        for (int l = 0; l < LANES; l++) begin
            a_arr[l] = AW'((l % 2 == 0) ? 300 : 332); d_arr[l] = 32'hB0000000 + DW'(l);
        end
        run_req(1'b0, "R6", 1'b0);
        clear_lanes();
        a_arr[0] = AW'(200); a_arr[1] = AW'(300); a_arr[2] = AW'(332);
        rd_arr[0] = 1'b1; rd_arr[1] = 1'b1; rd_arr[2] = 1'b1;
        run_req(1'b0, "R6", 1'b0);
        chk(lane_rdata[0 +: DW] == 32'hA000001F, "R6", "word 200 holds lane 31 data",
            longint'(lane_rdata[0 +: DW]), 32'hA000001F);
        chk(lane_rdata[DW +: DW] == 32'hB000001E, "R6", "word 300 holds lane 30 data",
            longint'(lane_rdata[DW +: DW]), 32'hB000001E);
        chk(lane_rdata[2*DW +: DW] == 32'hB000001F, "R6", "word 332 holds lane 31 data",
            longint'(lane_rdata[2*DW +: DW]), 32'hB000001F);

        // R8: empty request
        clear_lanes();
        run_req(1'b0, "R8", 1'b0);

        // R7: stride-32 read with a conflicting write held on req_valid while busy
        set_stride(1, 32, 1'b1, 0);
        run_req(1'b0, "R3", 1'b1);
        repeat (2) begin
            @(posedge clk); #1;
            chk(!done, "R7", "held request not taken", longint'(done), 0);
        end
        set_stride(0, 1, 1'b1, 0);
        run_req(1'b0, "R7", 1'b0);

        $display("  Result: errors=%0d of %0d checks", errors, nchecks);
        $finish;
    end

endmodule